// File: doc/BRIEF.md
# Parallel ATA Host Programmed-I/O Register Controller

This block is the host end of a simple parallel ATA link that moves data by programmed I/O only. Local logic asks for one register access at a time. A request gives a two-bit bank select, a 3-bit register number, a direction and a 16-bit write word. The controller then runs the drive-side handshake. It drives two active-low bank selects, the register address and separate active-low read and write strobes. It captures the 16-bit word the drive returns on a read. It stretches the active strobe for as long as the drive holds its ready line low.

The block also produces the drive's active-low reset pulse. It passes the drive's active-low interrupt into the clock domain as a level. A built-in command sequencer loads the seven parameter registers of the command bank in ascending order and writes the command register last. It places a drive-select input into the drive/head register on the way. While a reset pulse, an access or a sequence is under way, new requests are turned away with a busy pulse.

Top module: `ataPioHost`

## Requirements
- R1: After `rstN` is released, `ideResetN` stays low for exactly RST_CYC clock cycles. A `driveReset` pulse taken while idle produces another low pulse of RST_CYC cycles. No bank select is asserted while `ideResetN` is low.
- R2: `reqSel`=01 asserts only `ideSelCmdN` and `reqSel`=10 asserts only `ideSelCtlN`, both low-active. `ideAddr` equals `reqAddr` for the whole access.
- R3: A request with `reqSel`=00 or 11 is refused. `reqErr` pulses high for one cycle, one cycle after the request. No bank select or strobe follows. The two bank selects are never low together.
- R4: On a write, `ideWrN` is low, `ideDataOe` is high and `ideDataOut` equals all 16 bits of `reqWdata` while the strobe is active. A strobe is only active while exactly one bank select is asserted. Both bank selects are high again in the cycle `reqDone` is high.
- R5: Each access has SETUP_CYC cycles with address and bank select but no strobe, then the strobe, then HOLD_CYC cycles with the bank select but no strobe. After that `reqDone` is high for one cycle. With `ideReady` high the strobe lasts STROBE_CYC cycles.
- R6: While `ideReady` is low, an active strobe is kept active. If `ideReady` is low in strobe cycles 1..N-1 and high from cycle N, the strobe lasts max(STROBE_CYC, N) cycles.
- R7: On a read, `ideRdN` is the active strobe. `rdData` takes the value of `ideDataIn` in the last strobe cycle and holds it.
- R8: `irq` is the inverse of `ideIntN` passed through SYNC_STAGES flops. With the default of 2 it follows a change after two rising edges.
- R9: A `reqValid`, `cmdStart` or `driveReset` that arrives while a reset pulse, an access or a sequence is in progress is ignored. `reqBusy` pulses one cycle later and no extra access is run.
- R10: `cmdStart` runs eight write accesses to the command bank (`reqSel`=01) at register numbers 0,1,...,7 in that order. Register i < 7 receives byte i of `cmdParams` (bits 8i+7..8i). Register 7 receives `cmdOpcode`. The upper 8 data bits are zero. `cmdDone` pulses after the last one.
- R11: In the register-6 write of a sequence, bit 4 is replaced by `cmdDrive`. The other bits of that byte come from `cmdParams` byte 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Single-access request |
| reqSel | input | 2 | Bank select: 01 command bank, 10 control bank |
| reqAddr | input | 3 | Register number within the bank |
| reqWrite | input | 1 | 1 write, 0 read |
| reqWdata | input | 16 | Write word |
| reqDone | output | 1 | One-cycle pulse at the end of an access |
| reqErr | output | 1 | One-cycle pulse: illegal bank select refused |
| reqBusy | output | 1 | One-cycle pulse: request refused while busy |
| rdData | output | 16 | Last captured read word |
| cmdStart | input | 1 | Start a command-issue sequence |
| cmdParams | input | 56 | Parameter bytes for registers 0..6 |
| cmdOpcode | input | 8 | Command byte for register 7 |
| cmdDrive | input | 1 | Drive-select bit for register 6 |
| cmdDone | output | 1 | One-cycle pulse when the command has been written |
| driveReset | input | 1 | Request a new drive reset pulse |
| busy | output | 1 | Reset, access or sequence in progress |
| irq | output | 1 | Synchronized, active-high drive interrupt |
| ideSelCmdN | output | 1 | Command-bank select, active low |
| ideSelCtlN | output | 1 | Control-bank select, active low |
| ideAddr | output | 3 | Register address to the drive |
| ideRdN | output | 1 | Read strobe, active low |
| ideWrN | output | 1 | Write strobe, active low |
| ideDataOut | output | 16 | Data driven toward the drive |
| ideDataOe | output | 1 | Output enable for ideDataOut |
| ideDataIn | input | 16 | Data returned by the drive |
| ideReady | input | 1 | Drive ready; low stretches the strobe |
| ideResetN | output | 1 | Drive reset, active low |
| ideIntN | input | 1 | Drive interrupt, active low, asynchronous |

## Verification
The assertions assume that `ideReady` changes in step with `clk`, because it reaches the state machine without a synchronizer. They also assume `cmdParams`, `cmdOpcode` and `cmdDrive` hold steady in the cycle `cmdStart` is taken. The timing parameters must all be at least one. The bench meets these assumptions by changing every input just after a falling edge. It lowers ready before the request and raises it just after a falling edge inside a chosen strobe cycle. The drive model derives its read word from the bank, the address and the current strobe cycle. That makes the word sampled on the last cycle distinguishable from the words on earlier cycles.

// File: rtl/ataPioPkg.sv
package ataPioPkg;
  localparam int ATA_DW      = 16;
  localparam int ATA_AW      = 3;
  localparam int ATA_REGS    = 1 << ATA_AW;
  localparam int ATA_BYTE    = 8;
  localparam int ATA_NPARAM  = ATA_REGS - 1;
  localparam int ATA_CMD_REG = ATA_REGS - 1;
  localparam int ATA_DRV_REG = ATA_REGS - 2;
  localparam int ATA_DRV_BIT = 4;

  localparam logic [1:0] SEL_CMD = 2'b01;
  localparam logic [1:0] SEL_CTL = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACTIVE, ST_HOLD, ST_RESET
  } ataState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic              loadExt;
    logic              loadSeq;
    logic              latchCmd;
    logic              capture;
    logic              busAct;
    logic              rdStrobe;
    logic              wrStrobe;
    logic              driveBus;
    logic [ATA_AW-1:0] seqIdx;
  } ataStrobe_t;
endpackage

// File: rtl/ataPioCtrl.sv
module ataPioCtrl
  import ataPioPkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 2,
  parameter int RST_CYC    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqSel,
  input  logic       reqWrite,
  input  logic       cmdStart,
  input  logic       driveReset,
  input  logic       ideReady,
  output ataStrobe_t ctl,
  output logic       reqDone,
  output logic       reqErr,
  output logic       reqBusy,
  output logic       cmdDone,
  output logic       busy,
  output logic       ideResetN
);
  localparam int MAX_AB = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_CD = (HOLD_CYC > RST_CYC) ? HOLD_CYC : RST_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_LD  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] STROBE_LD = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] HOLD_LD   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] RST_LD    = CW'(RST_CYC - 1);
  localparam logic [ATA_AW-1:0] LAST_IDX = ATA_AW'(ATA_CMD_REG);

  ataState_t         state;
  logic [CW-1:0]     cnt;
  logic              seqActive;
  logic [ATA_AW-1:0] seqIdx;
  logic              wrFlag;

  logic selLegal, idleFree, launchSeq, takeRst, takeCmd, takeReq, lastCnt;

  always_comb begin
    selLegal  = (reqSel == SEL_CMD) || (reqSel == SEL_CTL);
    lastCnt   = (cnt == '0);
    launchSeq = (state == ST_IDLE) && seqActive;
    idleFree  = (state == ST_IDLE) && !seqActive;
    takeRst   = idleFree && driveReset;
    takeCmd   = idleFree && !driveReset && cmdStart;
    takeReq   = idleFree && !driveReset && !cmdStart && reqValid;
    busy      = (state != ST_IDLE) || seqActive;
    ideResetN = (state != ST_RESET);

    ctl.loadExt  = takeReq && selLegal;
    ctl.loadSeq  = launchSeq;
    ctl.latchCmd = takeCmd;
    ctl.busAct   = (state == ST_SETUP) || (state == ST_ACTIVE) || (state == ST_HOLD);
    ctl.rdStrobe = (state == ST_ACTIVE) && !wrFlag;
    ctl.wrStrobe = (state == ST_ACTIVE) && wrFlag;
    ctl.capture  = ctl.rdStrobe && lastCnt && ideReady;
    ctl.driveBus = ctl.busAct && wrFlag;
    ctl.seqIdx   = seqIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RESET;
      cnt       <= RST_LD;
      seqActive <= 1'b0;
      seqIdx    <= '0;
      wrFlag    <= 1'b0;
      reqDone   <= 1'b0;
      reqErr    <= 1'b0;
      reqBusy   <= 1'b0;
      cmdDone   <= 1'b0;
    end else begin
      reqDone <= 1'b0;
      cmdDone <= 1'b0;
      reqErr  <= takeReq && !selLegal;
      reqBusy <= (reqValid && !takeReq) || (cmdStart && !takeCmd) ||
                 (driveReset && !takeRst);
      case (state)
        ST_IDLE: begin
          if (launchSeq) begin
            state  <= ST_SETUP;
            cnt    <= SETUP_LD;
            wrFlag <= 1'b1;
          end else if (takeRst) begin
            state <= ST_RESET;
            cnt   <= RST_LD;
          end else if (takeCmd) begin
            seqActive <= 1'b1;
            seqIdx    <= '0;
          end else if (takeReq && selLegal) begin
            state  <= ST_SETUP;
            cnt    <= SETUP_LD;
            wrFlag <= reqWrite;
          end
        end
        ST_SETUP: begin
          if (lastCnt) begin
            state <= ST_ACTIVE;
            cnt   <= STROBE_LD;
          end else cnt <= cnt - 1'b1;
        end
        ST_ACTIVE: begin
          if (!lastCnt) cnt <= cnt - 1'b1;
          else if (ideReady) begin
            state <= ST_HOLD;
            cnt   <= HOLD_LD;
          end
        end
        ST_HOLD: begin
          if (!lastCnt) cnt <= cnt - 1'b1;
          else begin
            state <= ST_IDLE;
            if (seqActive) begin
              if (seqIdx == LAST_IDX) begin
                seqActive <= 1'b0;
                cmdDone   <= 1'b1;
              end else seqIdx <= seqIdx + 1'b1;
            end else reqDone <= 1'b1;
          end
        end
        ST_RESET: begin
          if (lastCnt) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: the first cycle with the bus claimed never carries a strobe
  assert_setup_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.busAct) |-> !(ctl.rdStrobe || ctl.wrStrobe));

  // R6: a strobe seen with ready low is still active next cycle
  assert_ready_stretch_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((ctl.rdStrobe || ctl.wrStrobe) && !ideReady) |=> (ctl.rdStrobe || ctl.wrStrobe));

  // R1: the drive bus stays idle while the drive is held in reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !ideResetN |-> !ctl.busAct);

  // R9: a request arriving while busy is answered with a busy pulse
  assert_busy_refuse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid) |=> reqBusy);

  // R5: completion is reported only after the bus has been released
  assert_done_after_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |-> !ctl.busAct);
endmodule

// File: rtl/ataPioData.sv
module ataPioData
  import ataPioPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ataStrobe_t                    ctl,
  input  logic [1:0]                    reqSel,
  input  logic [ATA_AW-1:0]             reqAddr,
  input  logic [ATA_DW-1:0]             reqWdata,
  input  logic [ATA_NPARAM*ATA_BYTE-1:0] cmdParams,
  input  logic [ATA_BYTE-1:0]           cmdOpcode,
  input  logic                          cmdDrive,
  input  logic [ATA_DW-1:0]             ideDataIn,
  input  logic                          ideIntN,
  output logic                          ideSelCmdN,
  output logic                          ideSelCtlN,
  output logic [ATA_AW-1:0]             ideAddr,
  output logic                          ideRdN,
  output logic                          ideWrN,
  output logic [ATA_DW-1:0]             ideDataOut,
  output logic                          ideDataOe,
  output logic [ATA_DW-1:0]             rdData,
  output logic                          irq
);
  logic [1:0]                     selReg;
  logic [ATA_AW-1:0]              addrReg;
  logic [ATA_DW-1:0]              wdReg;
  logic [ATA_NPARAM*ATA_BYTE-1:0] parReg;
  logic [ATA_BYTE-1:0]            opReg;
  logic                           drvReg;
  logic [ATA_BYTE-1:0]            seqByte;

  always_comb begin
    seqByte = opReg;
    for (int i = 0; i < ATA_NPARAM; i++)
      if (ctl.seqIdx == ATA_AW'(i)) seqByte = parReg[i*ATA_BYTE +: ATA_BYTE];
    if (ctl.seqIdx == ATA_AW'(ATA_DRV_REG)) seqByte[ATA_DRV_BIT] = drvReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg  <= '0;
      addrReg <= '0;
      wdReg   <= '0;
      parReg  <= '0;
      opReg   <= '0;
      drvReg  <= 1'b0;
      rdData  <= '0;
    end else begin
      if (ctl.latchCmd) begin
        parReg <= cmdParams;
        opReg  <= cmdOpcode;
        drvReg <= cmdDrive;
      end
      if (ctl.loadExt) begin
        selReg  <= reqSel;
        addrReg <= reqAddr;
        wdReg   <= reqWdata;
      end else if (ctl.loadSeq) begin
        selReg  <= SEL_CMD;
        addrReg <= ctl.seqIdx;
        wdReg   <= {{(ATA_DW-ATA_BYTE){1'b0}}, seqByte};
      end
      if (ctl.capture) rdData <= ideDataIn;
    end
  end

  always_comb begin
    ideSelCmdN = !(ctl.busAct && selReg[0]);
    ideSelCtlN = !(ctl.busAct && selReg[1]);
    ideAddr    = addrReg;
    ideRdN     = !ctl.rdStrobe;
    ideWrN     = !ctl.wrStrobe;
    ideDataOut = wdReg;
    ideDataOe  = ctl.driveBus;
  end

  // Interrupt synchronizer, one flop per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    logic q;
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) q <= 1'b0;
        else q <= !ideIntN;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) q <= 1'b0;
        else q <= gSync[g-1].q;
    end
  end
  assign irq = gSync[SYNC_STAGES-1].q;

  // R3: never both banks at once
  assert_one_bank_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(!ideSelCmdN && !ideSelCtlN));

  // R4: a strobe only appears inside a selected bank
  assert_strobe_in_bank_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ideRdN || !ideWrN) |-> (ideSelCmdN != ideSelCtlN));

  // R4: write word held steady across the write strobe
  assert_wdata_steady_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ideWrN && $past(!ideWrN)) |-> $stable(ideDataOut));
endmodule

// File: rtl/ataPioHost.sv
module ataPioHost
  import ataPioPkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int STROBE_CYC  = 3,
  parameter int HOLD_CYC    = 2,
  parameter int RST_CYC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqSel,
  input  logic [2:0]  reqAddr,
  input  logic        reqWrite,
  input  logic [15:0] reqWdata,
  output logic        reqDone,
  output logic        reqErr,
  output logic        reqBusy,
  output logic [15:0] rdData,
  input  logic        cmdStart,
  input  logic [55:0] cmdParams,
  input  logic [7:0]  cmdOpcode,
  input  logic        cmdDrive,
  output logic        cmdDone,
  input  logic        driveReset,
  output logic        busy,
  output logic        irq,
  output logic        ideSelCmdN,
  output logic        ideSelCtlN,
  output logic [2:0]  ideAddr,
  output logic        ideRdN,
  output logic        ideWrN,
  output logic [15:0] ideDataOut,
  output logic        ideDataOe,
  input  logic [15:0] ideDataIn,
  input  logic        ideReady,
  output logic        ideResetN,
  input  logic        ideIntN
);
  ataStrobe_t ctl;

  ataPioCtrl #(
    .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC(HOLD_CYC), .RST_CYC(RST_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSel(reqSel),
    .reqWrite(reqWrite), .cmdStart(cmdStart), .driveReset(driveReset),
    .ideReady(ideReady), .ctl(ctl), .reqDone(reqDone), .reqErr(reqErr),
    .reqBusy(reqBusy), .cmdDone(cmdDone), .busy(busy), .ideResetN(ideResetN)
  );

  ataPioData #(.SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqSel(reqSel), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .cmdParams(cmdParams), .cmdOpcode(cmdOpcode),
    .cmdDrive(cmdDrive), .ideDataIn(ideDataIn), .ideIntN(ideIntN),
    .ideSelCmdN(ideSelCmdN), .ideSelCtlN(ideSelCtlN), .ideAddr(ideAddr),
    .ideRdN(ideRdN), .ideWrN(ideWrN), .ideDataOut(ideDataOut),
    .ideDataOe(ideDataOe), .rdData(rdData), .irq(irq)
  );
endmodule

// File: tb/sim_ataPioHost.sv
module sim_ataPioHost;
  localparam int CLK_PERIOD = 10;
  localparam int SETUP_C  = 2;
  localparam int STROBE_C = 3;
  localparam int HOLD_C   = 2;
  localparam int RST_C    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, cmdStart = 1'b0, cmdDrive = 1'b0;
  logic driveReset = 1'b0, ideReady = 1'b1, ideIntN = 1'b1;
  logic [1:0]  reqSel = 2'b01;
  logic [2:0]  reqAddr = '0;
  logic [15:0] reqWdata = '0, ideDataIn = '0;
  logic [55:0] cmdParams = '0;
  logic [7:0]  cmdOpcode = '0;
  logic reqDone, reqErr, reqBusy, cmdDone, busy, irq;
  logic ideSelCmdN, ideSelCtlN, ideRdN, ideWrN, ideDataOe, ideResetN;
  logic [2:0]  ideAddr;
  logic [15:0] rdData, ideDataOut;

  ataPioHost #(.SETUP_CYC(SETUP_C), .STROBE_CYC(STROBE_C), .HOLD_CYC(HOLD_C),
               .RST_CYC(RST_C), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSel(reqSel),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .reqDone(reqDone), .reqErr(reqErr), .reqBusy(reqBusy), .rdData(rdData),
    .cmdStart(cmdStart), .cmdParams(cmdParams), .cmdOpcode(cmdOpcode),
    .cmdDrive(cmdDrive), .cmdDone(cmdDone), .driveReset(driveReset),
    .busy(busy), .irq(irq), .ideSelCmdN(ideSelCmdN), .ideSelCtlN(ideSelCtlN),
    .ideAddr(ideAddr), .ideRdN(ideRdN), .ideWrN(ideWrN),
    .ideDataOut(ideDataOut), .ideDataOe(ideDataOe), .ideDataIn(ideDataIn),
    .ideReady(ideReady), .ideResetN(ideResetN), .ideIntN(ideIntN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive model: read word, ready release, write log
  int actRun = 0;
  int rdyHoldN = 0;
  int strobeCount = 0;
  int logN = 0;
  logic [20:0] logArr [0:31];

  always @(negedge clk) begin
    if (!ideRdN || !ideWrN) actRun++;
    else actRun = 0;
    if (actRun == 1) strobeCount++;
    if (actRun == 1 && !ideWrN && logN < 32) begin
      logArr[logN] = {ideSelCtlN, ideSelCmdN, ideAddr, ideDataOut};
      logN++;
    end
    if (rdyHoldN != 0 && actRun == rdyHoldN) begin
      ideReady = 1'b1;
      rdyHoldN = 0;
    end
    ideDataIn = 16'hC000 | (!ideSelCtlN ? 16'h0800 : 16'h0000)
              | ({13'b0, ideAddr} << 4);
    ideDataIn = ideDataIn + 16'(actRun);
  end

  function automatic logic [15:0] readWord(input logic [1:0] sel, input logic [2:0] a, input int n);
    logic [15:0] v;
    v = 16'hC000 | ((sel == 2'b10) ? 16'h0800 : 16'h0000) | ({13'b0, a} << 4);
    return v + 16'(n);
  endfunction

  task automatic doAccess(input logic [1:0] sel, input logic [2:0] a, input bit wr,
                          input logic [15:0] wd, input int stretchN);
    int setupN, actN, holdN, bad, expAct;
    bit got;
    @(negedge clk);
    reqSel = sel; reqAddr = a; reqWrite = wr; reqWdata = wd; reqValid = 1'b1;
    if (stretchN > 0) begin ideReady = 1'b0; rdyHoldN = stretchN; end
    @(negedge clk);
    reqValid = 1'b0;
    setupN = 0; actN = 0; holdN = 0; bad = 0; got = 0;
    for (int t = 0; t < 200 && !got; t++) begin
      if (reqDone) got = 1;
      else begin
        if (ideSelCmdN != (sel != 2'b01) || ideSelCtlN != (sel != 2'b10) || ideAddr != a) bad++;
        if (!ideRdN || !ideWrN) begin
          actN++;
          if (wr && (ideWrN || !ideRdN || ideDataOut != wd || !ideDataOe)) bad++;
          if (!wr && (ideRdN || !ideWrN)) bad++;
        end else if (actN == 0) setupN++;
        else holdN++;
        @(negedge clk);
      end
    end
    expAct = (stretchN > STROBE_C) ? stretchN : STROBE_C;
    chk(got, "R5", "reqDone seen", 32'(got), 1);
    chk(setupN == SETUP_C, "R5", "setup cycles", 32'(setupN), 32'(SETUP_C));
    chk(actN == expAct, (stretchN > 0) ? "R6" : "R5", "strobe cycles", 32'(actN), 32'(expAct));
    chk(holdN == HOLD_C, "R5", "hold cycles", 32'(holdN), 32'(HOLD_C));
    chk(bad == 0, wr ? "R4" : "R2", "bank/addr/data during access", 32'(bad), 0);
    chk(ideSelCmdN && ideSelCtlN, "R4", "selects released at done",
        {30'b0, ideSelCtlN, ideSelCmdN}, 3);
    if (!wr) chk(rdData == readWord(sel, a, expAct), "R7", "read word",
                 32'(rdData), 32'(readWord(sel, a, expAct)));
    ideReady = 1'b1; rdyHoldN = 0;
  endtask

  task automatic runSeq(input bit drv, input logic [7:0] p6, input logic [7:0] op,
                        input bit poke);
    logic [7:0] exp;
    bit got;
    int n0;
    for (int i = 0; i < 6; i++) cmdParams[i*8 +: 8] = 8'(8'h10 * (i + 1) + i);
    cmdParams[55:48] = p6; cmdOpcode = op; cmdDrive = drv;
    @(negedge clk);
    logN = 0; n0 = strobeCount;
    cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      reqSel = 2'b01; reqAddr = 3'd5; reqWrite = 1'b1; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      chk(reqBusy, "R9", "busy during sequence", 32'(reqBusy), 1);
    end
    got = 0;
    for (int t = 0; t < 500 && !got; t++) begin
      if (cmdDone) got = 1; else @(negedge clk);
    end
    chk(got, "R10", "cmdDone seen", 32'(got), 1);
    chk(logN == 8 && strobeCount - n0 == 8, "R10", "write count", 32'(logN), 8);
    for (int i = 0; i < 8 && i < logN; i++) begin
      if (i == 7) exp = op;
      else if (i == 6) exp = (p6 & 8'hEF) | {3'b0, drv, 4'b0};
      else exp = cmdParams[i*8 +: 8];
      chk(logArr[i] == {1'b1, 1'b0, 3'(i), 8'h00, exp}, (i == 6) ? "R11" : "R10",
          "sequence write", 32'(logArr[i]), 32'({1'b1, 1'b0, 3'(i), 8'h00, exp}));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", "run ended", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lowN;
    bit okq;
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk(!ideResetN && ideSelCmdN && ideSelCtlN && ideRdN && ideWrN && !irq && !reqDone,
        "R1", "reset state", {26'b0, ideResetN, ideSelCmdN, ideSelCtlN, ideRdN, ideWrN, irq}, 6'b011110);
    rstN = 1'b1;
    lowN = 0;
    for (int t = 0; t < 100 && !ideResetN; t++) begin lowN++; @(negedge clk); end
    chk(lowN == RST_C, "R1", "power-up reset width", 32'(lowN), 32'(RST_C));

    // R2/R4/R5/R7: sweep both banks, all addresses, both directions
    for (int s = 1; s <= 2; s++)
      for (int a = 0; a < 8; a++)
        for (int w = 0; w < 2; w++)
          doAccess(2'(s), 3'(a), w[0], 16'h8001 ^ 16'(a * 16'h1111) ^ 16'(s << 12), 0);

    // R6: ready stretching sweep
    for (int n = 1; n <= 6; n++) begin
      doAccess(2'b01, 3'd5, 1'b0, 16'h0, n);
      doAccess(2'b10, 3'd2, 1'b1, 16'h5A00 + 16'(n), n);
    end

    // R3: illegal bank selections
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      reqSel = (k == 0) ? 2'b00 : 2'b11; reqAddr = 3'd1; reqWrite = 1'b1; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      chk(reqErr, "R3", "error pulse", 32'(reqErr), 1);
      okq = 1;
      for (int t = 0; t < 8; t++) begin
        if (!ideSelCmdN || !ideSelCtlN || !ideRdN || !ideWrN || reqDone) okq = 0;
        @(negedge clk);
      end
      chk(okq && !reqErr, "R3", "no access after refusal", 32'(okq), 1);
    end

    // R9: second request during an access
    @(negedge clk);
    lowN = strobeCount; logN = 0;
    reqSel = 2'b01; reqAddr = 3'd2; reqWrite = 1'b1; reqWdata = 16'h1234; reqValid = 1'b1;
    @(negedge clk);
    reqAddr = 3'd3; reqWdata = 16'h4321;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqBusy, "R9", "busy during access", 32'(reqBusy), 1);
    okq = 0;
    for (int t = 0; t < 50 && !okq; t++) begin if (reqDone) okq = 1; else @(negedge clk); end
    repeat (10) @(negedge clk);
    chk(strobeCount - lowN == 1 && logArr[0][18:16] == 3'd2, "R9", "single strobe, first address",
        32'(strobeCount - lowN), 1);

    // R10/R11: command sequences
    runSeq(1'b1, 8'hA0, 8'hEC, 1'b1);
    runSeq(1'b0, 8'hFF, 8'h20, 1'b0);

    // R8: interrupt synchronization
    @(negedge clk);
    ideIntN = 1'b0;
    @(negedge clk);
    chk(!irq, "R8", "irq after one edge", 32'(irq), 0);
    @(negedge clk);
    chk(irq, "R8", "irq after two edges", 32'(irq), 1);
    ideIntN = 1'b1;
    @(negedge clk);
    chk(irq, "R8", "irq held one edge", 32'(irq), 1);
    @(negedge clk);
    chk(!irq, "R8", "irq cleared", 32'(irq), 0);

    // R1/R9: drive reset on request, with a refused request inside it
    driveReset = 1'b1;
    @(negedge clk);
    driveReset = 1'b0;
    lowN = 0;
    for (int t = 0; t < 100 && !ideResetN; t++) begin
      if (t == 0) begin reqSel = 2'b01; reqValid = 1'b1; end
      if (t == 1) begin
        reqValid = 1'b0;
        chk(reqBusy, "R9", "busy during reset", 32'(reqBusy), 1);
      end
      if (!ideSelCmdN || !ideSelCtlN) chk(0, "R1", "select during reset", 0, 1);
      lowN++;
      @(negedge clk);
    end
    chk(lowN == RST_C, "R1", "requested reset width", 32'(lowN), 32'(RST_C));
    repeat (3) @(negedge clk);
    chk(ideSelCmdN && ideSelCtlN && ideRdN && ideWrN, "R9", "refused request not run",
        {28'b0, ideSelCmdN, ideSelCtlN, ideRdN, ideWrN}, 15);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule